// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block sits beside a shared two-port memory and watches the left and right access ports. Each port presents a chip enable, an address and a write strobe. When both ports are enabled on the same address, the block decides which side keeps access and pulls the active-low busy signal of the other side. It also removes that side's write strobe before the strobe reaches the array. Only enable and address matter here. Whether either access is a read or a write plays no part in the decision.

Arrival order is judged one clock at a time. A port that already held its enable and address in the previous cycle counts as earlier than a port that has just appeared on that address. When both appear in the same cycle, the left side wins. Once a side holds the grant, it keeps it for as long as the collision lasts. Busy outputs come from a register and change one clock after the inputs that cause them are sampled.

A mode input selects master or slave operation. A master arbitrates and drives busy. A slave does no arbitration and keeps its busy outputs high. It instead takes one busy input per port, and a low on that input blocks that port's writes. This lets several slices of a wide word follow one master's decision.

Top module: `busy_arbiter`

## Requirements
- R1: A collision exists only when both chip enables are high and the two addresses are equal. The write strobes play no part, so two reads on one address also raise busy on the losing side.
- R2: In master mode, if one port held its enable high on the same address in the previous cycle and the other port has just arrived, the earlier port wins. The newcomer's busy output goes low on the clock edge after the collision is first sampled.
- R3: The two busy outputs are never low at the same time.
- R4: In master mode, the gated write output of a port whose busy output is low is held low. The winning port's write strobe passes through unchanged.
- R5: In slave mode, both busy outputs stay high. A port's gated write equals its write strobe when its busy input is high and is held low when that input is low.
- R6: When there is no address match, or either chip enable is low, both busy outputs are high one clock later.
- R7: Busy on the losing side returns high one clock after the address match ends or the winner's chip enable drops.
- R8: When both ports arrive on the same address in the same cycle, the left port wins and the right busy output goes low.
- R9: While a collision persists, the grant stays with its holder. This holds even after both ports have been steady long enough to look simultaneous.
- R10: After reset, both busy outputs are high and no grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | 1 = arbitrate and drive busy, 0 = slave (busy inputs inhibit writes) |
| leftCe | input | 1 | Left chip enable, active high |
| leftAddr | input | ADDR_W | Left address |
| leftWe | input | 1 | Left write strobe, active high |
| rightCe | input | 1 | Right chip enable, active high |
| rightAddr | input | ADDR_W | Right address |
| rightWe | input | 1 | Right write strobe, active high |
| leftBusyIn | input | 1 | Slave-mode left write inhibit, active low |
| rightBusyIn | input | 1 | Slave-mode right write inhibit, active low |
| leftBusyN | output | 1 | Left busy, active low |
| rightBusyN | output | 1 | Right busy, active low |
| leftWeGated | output | 1 | Left write strobe after inhibit |
| rightWeGated | output | 1 | Right write strobe after inhibit |

## Verification
Several properties are checked by assertions on every cycle. The busy outputs are never low together. A loser in master mode and an inhibited port in slave mode never produce a gated write. A held grant survives each cycle in which the collision continues, and a cycle without a collision always clears busy. Other behaviour can only be shown by the bench's scenarios, where a cycle model is compared against the outputs on every clock. This covers which port wins for each arrival order, the one-clock delay, the release when the winner leaves, and slave-mode inhibit under changing busy inputs.

// File: rtl/busy_arb_pkg.sv
package busy_arb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_t;

  // datapath -> control
  typedef struct packed {
    logic collide;
    logic leftHeld;
    logic rightHeld;
  } arbStrobes_t;

  // control -> datapath
  typedef struct packed {
    logic leftBlock;
    logic rightBlock;
  } blockStrobes_t;

endpackage

// File: rtl/busy_arb_dp.sv
module busy_arb_dp
  import busy_arb_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              masterMode,
  input  logic              leftCe,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftWe,
  input  logic              rightCe,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightWe,
  input  logic              leftBusyIn,
  input  logic              rightBusyIn,
  input  blockStrobes_t     blk,
  output arbStrobes_t       strb,
  output logic              leftBusyN,
  output logic              rightBusyN,
  output logic              leftWeGated,
  output logic              rightWeGated
);

  logic              prevLeftCe, prevRightCe;
  logic [ADDR_W-1:0] prevLeftAddr, prevRightAddr;
  logic              leftInhibit, rightInhibit;

  // last-cycle request of each port, used to judge arrival order
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevLeftCe    <= 1'b0;
      prevRightCe   <= 1'b0;
      prevLeftAddr  <= '0;
      prevRightAddr <= '0;
    end else begin
      prevLeftCe    <= leftCe;
      prevRightCe   <= rightCe;
      prevLeftAddr  <= leftAddr;
      prevRightAddr <= rightAddr;
    end
  end

  always_comb begin
    strb.collide   = leftCe && rightCe && (leftAddr == rightAddr);
    strb.leftHeld  = leftCe && prevLeftCe && (leftAddr == prevLeftAddr);
    strb.rightHeld = rightCe && prevRightCe && (rightAddr == prevRightAddr);
  end

  assign leftBusyN  = !blk.leftBlock;
  assign rightBusyN = !blk.rightBlock;

  always_comb begin
    if (masterMode) begin
      leftInhibit  = blk.leftBlock;
      rightInhibit = blk.rightBlock;
    end else begin
      leftInhibit  = !leftBusyIn;
      rightInhibit = !rightBusyIn;
    end
    leftWeGated  = leftWe && !leftInhibit;
    rightWeGated = rightWe && !rightInhibit;
  end

  AST_IDLE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.collide |=> (leftBusyN && rightBusyN)); // R6
  AST_LOSER_NO_WRITE_L: assert property (@(posedge clk) disable iff (!rst_n)
    (masterMode && !leftBusyN) |-> !leftWeGated); // R4
  AST_LOSER_NO_WRITE_R: assert property (@(posedge clk) disable iff (!rst_n)
    (masterMode && !rightBusyN) |-> !rightWeGated); // R4
  AST_SLAVE_INHIBIT_L: assert property (@(posedge clk) disable iff (!rst_n)
    (!masterMode && !leftBusyIn) |-> !leftWeGated); // R5
  AST_SLAVE_INHIBIT_R: assert property (@(posedge clk) disable iff (!rst_n)
    (!masterMode && !rightBusyIn) |-> !rightWeGated); // R5

endmodule

// File: rtl/busy_arb_ctl.sv
module busy_arb_ctl
  import busy_arb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          masterMode,
  input  arbStrobes_t   strb,
  output blockStrobes_t blk
);

  owner_t owner, ownerNext;
  logic   rightFirst;

  assign rightFirst = strb.rightHeld && !strb.leftHeld;

  always_comb begin
    if (!masterMode || !strb.collide) begin
      ownerNext = OWN_NONE;
    end else if (owner != OWN_NONE) begin
      ownerNext = owner;            // held grant survives the collision
    end else if (rightFirst) begin
      ownerNext = OWN_RIGHT;
    end else begin
      ownerNext = OWN_LEFT;         // left first, or same-cycle tie
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner <= OWN_NONE;
    else        owner <= ownerNext;
  end

  assign blk.leftBlock  = (owner == OWN_RIGHT);
  assign blk.rightBlock = (owner == OWN_LEFT);

  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({blk.leftBlock, blk.rightBlock})); // R3
  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (masterMode && strb.collide && owner != OWN_NONE) |=> $stable(owner)); // R9
  AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (masterMode && strb.collide && owner == OWN_NONE && !rightFirst)
      |=> blk.rightBlock); // R8
  AST_EARLY_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (masterMode && strb.collide && owner == OWN_NONE && rightFirst)
      |=> blk.leftBlock); // R2
  AST_SLAVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !masterMode |=> (owner == OWN_NONE)); // R5

endmodule

// File: rtl/busy_arbiter.sv
module busy_arbiter
  import busy_arb_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              masterMode,
  input  logic              leftCe,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftWe,
  input  logic              rightCe,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightWe,
  input  logic              leftBusyIn,
  input  logic              rightBusyIn,
  output logic              leftBusyN,
  output logic              rightBusyN,
  output logic              leftWeGated,
  output logic              rightWeGated
);

  arbStrobes_t   strb;
  blockStrobes_t blk;

  busy_arb_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .masterMode(masterMode),
    .leftCe(leftCe), .leftAddr(leftAddr), .leftWe(leftWe),
    .rightCe(rightCe), .rightAddr(rightAddr), .rightWe(rightWe),
    .leftBusyIn(leftBusyIn), .rightBusyIn(rightBusyIn),
    .blk(blk), .strb(strb),
    .leftBusyN(leftBusyN), .rightBusyN(rightBusyN),
    .leftWeGated(leftWeGated), .rightWeGated(rightWeGated)
  );

  busy_arb_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .masterMode(masterMode),
    .strb(strb), .blk(blk)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (leftBusyN && rightBusyN)); // R10

endmodule

// File: tb/busy_arbiter_bench.sv
`timescale 1ns/1ps
module busy_arbiter_bench;
  localparam int AW = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic masterMode = 1'b1;
  logic leftCe = 0, rightCe = 0, leftWe = 0, rightWe = 0;
  logic [AW-1:0] leftAddr = '0, rightAddr = '0;
  logic leftBusyIn = 1, rightBusyIn = 1;
  logic leftBusyN, rightBusyN, leftWeGated, rightWeGated;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string reqTag = "R10";

  // reference model state: 0 none, 1 left owns, 2 right owns
  int mOwner = 0;
  logic mPrevLce = 0, mPrevRce = 0;
  logic [AW-1:0] mPrevLa = '0, mPrevRa = '0;

  always #2 clk = ~clk;

  busy_arbiter #(.ADDR_W(AW)) u_busy_arbiter (
    .clk(clk), .rst_n(rst_n), .masterMode(masterMode),
    .leftCe(leftCe), .leftAddr(leftAddr), .leftWe(leftWe),
    .rightCe(rightCe), .rightAddr(rightAddr), .rightWe(rightWe),
    .leftBusyIn(leftBusyIn), .rightBusyIn(rightBusyIn),
    .leftBusyN(leftBusyN), .rightBusyN(rightBusyN),
    .leftWeGated(leftWeGated), .rightWeGated(rightWeGated)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mOwner = 0; mPrevLce = 0; mPrevRce = 0; mPrevLa = '0; mPrevRa = '0;
    end else begin
      bit coll, lh, rh;
      coll = leftCe && rightCe && (leftAddr == rightAddr);
      lh = leftCe && mPrevLce && (leftAddr == mPrevLa);
      rh = rightCe && mPrevRce && (rightAddr == mPrevRa);
      if (!masterMode || !coll) mOwner = 0;
      else if (mOwner == 0) mOwner = (rh && !lh) ? 2 : 1;
      mPrevLce = leftCe; mPrevRce = rightCe;
      mPrevLa = leftAddr; mPrevRa = rightAddr;
    end
  end

  task automatic cmp(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %b expected %b", reqTag, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic eL, eR, gL, gR;
      eL = (mOwner != 2);
      eR = (mOwner != 1);
      gL = leftWe && !(masterMode ? (mOwner == 2) : !leftBusyIn);
      gR = rightWe && !(masterMode ? (mOwner == 1) : !rightBusyIn);
      cmp("leftBusyN", leftBusyN, eL);
      cmp("rightBusyN", rightBusyN, eR);
      cmp("leftWeGated", leftWeGated, gL);
      cmp("rightWeGated", rightWeGated, gR);
      cmp("R3 not both busy", !(!leftBusyN && !rightBusyN), 1'b1);
    end
  end

  task automatic drive(input logic lce, input logic [AW-1:0] la, input logic lw,
                       input logic rce, input logic [AW-1:0] ra, input logic rw);
    @(negedge clk); #1;
    leftCe = lce; leftAddr = la; leftWe = lw;
    rightCe = rce; rightAddr = ra; rightWe = rw;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, '0, 0, 0, '0, 0);
  endtask

  initial begin
    #40000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    reqTag = "R10";
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    idle(2);

    reqTag = "R1";  // reads only, same address -> busy; different address -> none
    drive(1, 15'h0123, 0, 1, 15'h0123, 0);
    drive(1, 15'h0123, 0, 1, 15'h0123, 0);
    drive(1, 15'h0123, 0, 1, 15'h0124, 0);
    drive(1, 15'h0124, 0, 0, 15'h0124, 1);
    idle(2);

    reqTag = "R2";  // left first, right joins
    drive(1, 15'h7FFE, 0, 0, '0, 0);
    drive(1, 15'h7FFE, 0, 1, 15'h7FFE, 0);
    reqTag = "R4";
    drive(1, 15'h7FFE, 1, 1, 15'h7FFE, 1);
    drive(1, 15'h7FFE, 0, 1, 15'h7FFE, 1);
    reqTag = "R7";  // winner drops enable
    drive(0, 15'h7FFE, 0, 1, 15'h7FFE, 1);
    drive(0, 15'h7FFE, 0, 1, 15'h7FFE, 0);
    idle(2);

    reqTag = "R2";  // right first, left joins
    drive(0, '0, 0, 1, 15'h0042, 0);
    drive(1, 15'h0042, 1, 1, 15'h0042, 1);
    reqTag = "R9";  // both steady for many cycles: grant stays right
    for (int i = 0; i < 6; i++) drive(1, 15'h0042, i[0], 1, 15'h0042, 1);
    reqTag = "R7";  // match ends by address move
    drive(1, 15'h0043, 1, 1, 15'h0042, 1);
    drive(1, 15'h0043, 1, 1, 15'h0042, 1);
    idle(2);

    reqTag = "R8";  // same-cycle arrival
    drive(1, 15'h7FFF, 1, 1, 15'h7FFF, 1);
    drive(1, 15'h7FFF, 1, 1, 15'h7FFF, 1);
    drive(1, 15'h7FFF, 1, 1, 15'h7FFF, 1);
    reqTag = "R6";
    drive(1, 15'h7FFF, 1, 0, 15'h7FFF, 1);
    drive(1, 15'h7FFF, 1, 0, 15'h7FFF, 1);
    idle(2);

    reqTag = "R5";  // slave mode
    @(negedge clk); #1 masterMode = 0;
    drive(1, 15'h0010, 1, 1, 15'h0010, 1);
    drive(1, 15'h0010, 1, 1, 15'h0010, 1);
    @(negedge clk); #1 leftBusyIn = 0;
    @(negedge clk); #1 begin leftBusyIn = 1; rightBusyIn = 0; end
    @(negedge clk); #1 begin leftBusyIn = 0; rightBusyIn = 0; end
    @(negedge clk); #1 begin leftBusyIn = 1; rightBusyIn = 1; end
    @(negedge clk);
    idle(1);
    @(negedge clk); #1 masterMode = 1;
    idle(2);

    reqTag = "R10";
    @(negedge clk); #1 rst_n = 0;
    drive(1, 15'h0001, 0, 1, 15'h0001, 0);
    @(negedge clk); #1 rst_n = 1;
    idle(1);
    reqTag = "R8";
    drive(1, 15'h0005, 0, 1, 15'h0005, 0);
    drive(1, 15'h0005, 0, 1, 15'h0005, 0);
    idle(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule